// File: doc/BRIEF.md
# Bit-Interleaved Backplane Demultiplexer

The block takes one serial backplane stream clocked at 16.384 MHz and splits it into four channel streams of 2.048 Mbps each. On the backplane, every channel bit is sent twice in back-to-back slots. Each bit time is eight slots long and serves the channels in ascending order. A rising edge on the sync input marks the first slot of a frame. The block keeps a slot counter and a bit-in-frame counter. It takes each channel's bit from the first slot of its pair and gives every channel a data bit, a one-cycle strobe and a frame-start flag.

Frame length is 256 bits in E1 mode and 193 bits in T1 mode, selected by a static mode pin. Between sync edges the counters run on by themselves. A sync edge that arrives somewhere other than the expected frame start realigns the counters at once and is reported on a one-cycle slip flag.

Top module: `bitmux_demux`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, every output (`ch_data_o`, `ch_strobe_o`, `frame_start_o`, `slip_o`) is 0, and the counters start at slot 0 of bit 0.
- R2: A rising edge of `sync_i` (high now, low on the previous clock) makes that clock cycle slot 0 of bit 0 of a frame. The next cycle is slot 1.
- R3: The slots of one bit time run 0 to 7. Slots 2k and 2k+1 belong to channel k. The channel bit is sampled in the even slot, and the value in the odd slot has no effect on any output.
- R4: `ch_data_o[k]` takes the sampled bit on the clock edge that ends the sample slot, which is one cycle later at the ports. It holds that value until the next sample for channel k.
- R5: `ch_strobe_o[k]` is high for exactly the one cycle in which `ch_data_o[k]` updates. At most one strobe bit is high in any cycle, and without realignment each channel strobes once every 8 cycles.
- R6: `frame_start_o[k]` is high together with `ch_strobe_o[k]` when the sampled bit is bit 0 of the frame, and is low otherwise.
- R7: With `t1_mode_i`=0 a frame has 256 bit times (2048 cycles). With `t1_mode_i`=1 it has 193 bit times (1544 cycles). Without any sync edge, frame starts repeat at that period.
- R8: After the first sync edge since reset, a sync edge that falls on any cycle other than the expected slot 0 of bit 0 raises `slip_o` for one cycle, one cycle later. A sync edge that falls on the expected start leaves `slip_o` low.
- R9: The first sync edge after reset never raises `slip_o`, wherever it falls.
- R10: Keeping `sync_i` high for more than one cycle has no effect beyond its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed slot clock (16.384 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Multiplexed serial data, one slot per clock |
| sync_i | input | 1 | Frame sync; its rising edge marks slot 0 of bit 0 |
| t1_mode_i | input | 1 | Frame length select: 0 = 256 bits, 1 = 193 bits |
| ch_data_o | output | 4 | Recovered data bit per channel |
| ch_strobe_o | output | 4 | One-cycle pulse per channel when its data bit updates |
| frame_start_o | output | 4 | Per-channel flag for bit 0 of a frame, valid with the strobe |
| slip_o | output | 1 | One-cycle pulse on a misplaced sync edge |

## Verification
The assertions assume that `t1_mode_i` changes only while reset is asserted. A change in the middle of a frame could leave the bit counter above the shorter frame length. They also assume that sync and data are synchronous to the slot clock. The bench changes the mode only inside its reset task, and it drives every input at the falling clock edge. Misplaced sync edges are produced on purpose, both before and after the first alignment, to exercise the slip and realignment checks. The odd slot of every pair always carries the inverse of the even slot, so any sample taken from the wrong slot changes the recovered data.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  typedef enum logic {
    FRM_E1 = 1'b0,
    FRM_T1 = 1'b1
  } frm_mode_e;
endpackage

// File: rtl/bmx_frame_timer.sv
module bmx_frame_timer
  import bmx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned E1_BITS   = 256,
  parameter int unsigned T1_BITS   = 193,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned BIT_W     = $clog2((E1_BITS > T1_BITS) ? E1_BITS : T1_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              t1_mode_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              slip_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [BIT_W-1:0]  E1_LAST   = BIT_W'(E1_BITS - 1);
  localparam logic [BIT_W-1:0]  T1_LAST   = BIT_W'(T1_BITS - 1);

  frm_mode_e         mode;
  logic              sync_q, locked_q, slip_q;
  logic              sync_edge, at_start;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BIT_W-1:0]  bit_q, bit_n, frame_last;

  assign mode       = frm_mode_e'(t1_mode_i);
  assign frame_last = (mode == FRM_T1) ? T1_LAST : E1_LAST;
  assign sync_edge  = sync_i & ~sync_q;
  assign at_start   = (slot_q == '0) && (bit_q == '0);

  // a sync edge overrides the flywheel position in the same cycle
  assign slot_o = sync_edge ? '0 : slot_q;
  assign bit_o  = sync_edge ? '0 : bit_q;

  always_comb begin
    slot_n = slot_o + 1'b1;
    bit_n  = bit_o;
    if (slot_o == SLOT_LAST) begin
      slot_n = '0;
      bit_n  = (bit_o >= frame_last) ? '0 : bit_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      locked_q <= 1'b0;
      slip_q   <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      sync_q   <= sync_i;
      locked_q <= locked_q | sync_edge;
      slip_q   <= sync_edge & locked_q & ~at_start;
      slot_q   <= slot_n;
      bit_q    <= bit_n;
    end
  end

  assign slip_o = slip_q;

  // R2
  realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_edge |=> (slot_q == SLOT_W'(1)) && (bit_q == '0));
  // R7
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= frame_last);
  // R8
  aligned_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_edge && at_start) |=> !slip_o);
  // R9
  first_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_edge && !locked_q) |=> !slip_o);
  // R8
  slip_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);
endmodule

// File: rtl/bmx_lane.sv
module bmx_lane #(
  parameter int unsigned CH       = 0,
  parameter int unsigned SLOT_REP = 2,
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned BIT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              ser_i,
  output logic              data_o,
  output logic              stb_o,
  output logic              fs_o
);
  // first slot of this channel's duplicated pair
  localparam logic [SLOT_W-1:0] SAMPLE_SLOT = SLOT_W'(CH * SLOT_REP);

  logic hit;
  assign hit = (slot_i == SAMPLE_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      stb_o  <= 1'b0;
      fs_o   <= 1'b0;
    end else begin
      stb_o <= hit;
      fs_o  <= hit && (bit_i == '0);
      if (hit) data_o <= ser_i;
    end
  end

  // R5
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  // R6
  fs_with_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> stb_o);
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_o |-> $stable(data_o));
endmodule

// File: rtl/bitmux_demux.sv
module bitmux_demux #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SLOT_REP = 2,
  parameter int unsigned E1_BITS  = 256,
  parameter int unsigned T1_BITS  = 193
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              sync_i,
  input  logic              t1_mode_i,
  output logic [NUM_CH-1:0] ch_data_o,
  output logic [NUM_CH-1:0] ch_strobe_o,
  output logic [NUM_CH-1:0] frame_start_o,
  output logic              slip_o
);
  localparam int unsigned NUM_SLOTS = NUM_CH * SLOT_REP;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned MAX_BITS  = (E1_BITS > T1_BITS) ? E1_BITS : T1_BITS;
  localparam int unsigned BIT_W     = $clog2(MAX_BITS);

  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitpos;

  bmx_frame_timer #(
    .NUM_SLOTS(NUM_SLOTS),
    .E1_BITS  (E1_BITS),
    .T1_BITS  (T1_BITS),
    .SLOT_W   (SLOT_W),
    .BIT_W    (BIT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .t1_mode_i(t1_mode_i),
    .slot_o   (slot),
    .bit_o    (bitpos),
    .slip_o   (slip_o)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    bmx_lane #(
      .CH      (k),
      .SLOT_REP(SLOT_REP),
      .SLOT_W  (SLOT_W),
      .BIT_W   (BIT_W)
    ) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .slot_i(slot),
      .bit_i (bitpos),
      .ser_i (ser_i),
      .data_o(ch_data_o[k]),
      .stb_o (ch_strobe_o[k]),
      .fs_o  (frame_start_o[k])
    );
  end

  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_strobe_o));
  // R6
  fs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(frame_start_o));
endmodule

// File: tb/test_bitmux_demux.sv
module test_bitmux_demux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       t1_mode_i = 1'b0;
  logic [3:0] ch_data_o, ch_strobe_o, frame_start_o;
  logic       slip_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side position and pending expectations
  int   pos_slot, pos_bit, flen;
  logic sync_prev;
  logic [3:0] pend_stb, pend_fs, exp_data;
  logic pend_slip;
  string cur_tag;

  always #2 clk_i = ~clk_i;

  bitmux_demux i_bitmux_demux (
    .clk_i, .rst_ni, .ser_i, .sync_i, .t1_mode_i,
    .ch_data_o, .ch_strobe_o, .frame_start_o, .slip_o
  );

  function automatic logic pat(int ch, int b);
    return logic'((((b * 5) + (ch * 3) + (b >> 3)) % 7) < 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] slot=%0d bit=%0d actual=%b expected=%b", tag, cur_tag, pos_slot, pos_bit, act, exp);
    end
  endtask

  task automatic check_pending();
    chk(ch_strobe_o === pend_stb, "R3 R5 strobe", ch_strobe_o, pend_stb);
    chk(frame_start_o === pend_fs, "R6 R7 frame_start", frame_start_o, pend_fs);
    chk(slip_o === pend_slip, "R8 slip", {3'b0, slip_o}, {3'b0, pend_slip});
    chk(ch_data_o === exp_data, "R4 data", ch_data_o, exp_data);
  endtask

  // called at a falling edge: check last cycle's result, drive next slot
  task automatic step(input logic s, input logic x_slip);
    int ch;
    logic d;
    check_pending();
    if (s && !sync_prev) begin pos_slot = 0; pos_bit = 0; end
    sync_prev = s;
    ch = pos_slot / 2;
    d = (pos_slot % 2 == 0) ? pat(ch, pos_bit) : ~pat(ch, pos_bit);
    ser_i = d;
    sync_i = s;
    pend_stb = '0;
    pend_fs = '0;
    if (pos_slot % 2 == 0) begin
      pend_stb[ch] = 1'b1;
      exp_data[ch] = d;
      if (pos_bit == 0) pend_fs[ch] = 1'b1;
    end
    pend_slip = x_slip;
    pos_slot++;
    if (pos_slot == 8) begin
      pos_slot = 0;
      pos_bit = (pos_bit == flen - 1) ? 0 : pos_bit + 1;
    end
    @(negedge clk_i);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic t1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    t1_mode_i = t1;
    sync_i = 1'b0;
    ser_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    flen = t1 ? 193 : 256;
    pos_slot = 0; pos_bit = 0; sync_prev = 1'b0;
    pend_stb = '0; pend_fs = '0; pend_slip = 1'b0; exp_data = '0;
  endtask

  // R1: outputs idle out of reset
  task automatic t_reset();
    cur_tag = "R1";
    do_reset(1'b0);
    chk(ch_data_o === 4'b0, "R1 data", ch_data_o, 4'b0);
    chk(ch_strobe_o === 4'b0, "R1 strobe", ch_strobe_o, 4'b0);
    chk(frame_start_o === 4'b0, "R1 frame_start", frame_start_o, 4'b0);
    chk(slip_o === 1'b0, "R1 slip", {3'b0, slip_o}, 4'b0);
  endtask

  // R2 R3 R4 R6: aligned E1 frames, odd slots carry inverted data
  task automatic t_e1_aligned();
    cur_tag = "R2 e1";
    run(19);
    step(1'b1, 1'b0);  // first sync, misplaced but R9 forbids slip
    run(2047);
    step(1'b1, 1'b0);  // exact start
    run(2047);
  endtask

  // R7: flywheel with no sync over three E1 frames
  task automatic t_flywheel();
    cur_tag = "R7 e1 flywheel";
    run(3 * 2048);
  endtask

  // R8: misplaced sync realigns and slips
  task automatic t_slip();
    cur_tag = "R8 slip";
    run(50 * 8 + 3);
    step(1'b1, 1'b1);
    run(2047);
    step(1'b1, 1'b0);
    run(555);
  endtask

  // R10: sync held high for many cycles
  task automatic t_long_sync();
    cur_tag = "R10 long sync";
    run(2048 - 555 - 1);
    step(1'b1, 1'b0);
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
    run(2048 - 12);
    step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    run(300);
  endtask

  // R7 R9: T1 frame length, first sync off-position without slip
  task automatic t_t1();
    cur_tag = "R9 t1";
    do_reset(1'b1);
    run(37);
    step(1'b1, 1'b0);
    run(1543);
    cur_tag = "R7 t1 flywheel";
    run(1544);
    step(1'b1, 1'b0);
    run(1543);
    step(1'b1, 1'b0);
    run(900);
    step(1'b1, 1'b1);
    run(40);
  endtask

  initial begin
    t_reset();
    t_e1_aligned();
    t_flywheel();
    t_slip();
    t_long_sync();
    t_t1();
    step(1'b0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule